// File: doc/BRIEF.md
# Video Control Register Slave with Colour Table Loader

This block is the two-wire (I2C) control port of a video output pipeline. It answers a fixed 7-bit device address (0x44, so 0x88 for writes and 0x89 for reads) and holds a bank of byte-wide configuration registers that the pipeline reads as a flat vector. The first byte after the write address is a subaddress. Each later data byte goes to that subaddress, and the subaddress then advances by one, so a host can fill a run of registers in a single transfer.

One reserved subaddress switches a write into colour-table mode. The next byte is the first table entry. After it, bytes arrive in groups of three (red, then green, then blue). Each complete group produces a one-cycle write strobe on the table RAM port with a 24-bit colour, and the entry number then steps forward. Reads start at the current subaddress and also advance by one per byte. Besides the registers, a read can return a fixed identification byte and a status byte. The status byte carries a sticky overflow flag, which is cleared by reading it, and the current field parity.

SCL and SDA are brought into the system clock domain through a two-flop synchroniser and are edge-detected there. SDA is open-drain: the block only ever pulls the line low, through `sda_oe`.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges device address 0x44 in both directions (address byte 0x88 for write, 0x89 for read). Any other address is not acknowledged, and the bytes that follow it are ignored until the next START.
- R2: In a write, the first byte after the address sets the subaddress. Each further byte is stored in the register at that subaddress (subaddresses 0x00 to NREG-1, reflected on `cfg_regs[8*k+:8]`), and the subaddress then increments by one.
- R3: A read returns the byte at the current subaddress and increments the subaddress after each byte. A master ACK continues the read. A master NACK ends it, and `sda_oe` is low before the STOP.
- R4: Subaddress 0x1C always reads 0x02, and writes to it change nothing.
- R5: Subaddress 0x1D is status. Bit 0 is a sticky flag, set by a one-cycle pulse on `ovf_evt` and cleared once that byte has been read. Bit 1 is 1 while `even_field` is high. Bits 7:2 read 0. Unmapped subaddresses read 0x00.
- R6: When the subaddress is 0xFF, the next byte is the starting table entry. Each following group of three bytes, in the order red, green, blue, gives one single-cycle `lut_we` pulse with `lut_rgb` = {R,G,B} (red in bits 23:16) at `lut_addr`. The entry number then increments. Configuration registers are not touched.
- R7: A group of fewer than three colour bytes that is ended by STOP is discarded, and no `lut_we` pulse is produced for it.
- R8: A STOP or repeated START in the middle of a byte returns the engine to idle. Registers committed earlier keep their values, and the next transfer works normally.
- R9: While reset is held, `sda_oe` and `lut_we` are low. After reset, all configuration registers and the sticky flag read 0.
- R10: The slave pulls SDA low in the acknowledge slot after its own address and after every byte written to it, and changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| ovf_evt | input | 1 | One-cycle pulse that sets the sticky overflow flag |
| even_field | input | 1 | High during the even video field |
| cfg_regs | output | 8*NREG | All configuration registers, register k in bits 8k+7:8k |
| lut_we | output | 1 | Colour table write strobe |
| lut_addr | output | LUT_AW | Colour table entry being written |
| lut_rgb | output | 24 | Colour for the entry, {R,G,B} |

## Verification
A wrong subaddress pointer appears on `cfg_regs` in the cycles just after the eighth SCL rise of a data byte, because the byte lands in the wrong slot. In a burst read it appears one byte later, as a value shifted by one position. A colour-group phase error shows up at the table port as a pulse that is missing, extra or misplaced, or as a colour whose components have rotated. These are seen on the byte where the stream is cut short or where the second group begins. A protocol engine stuck in the wrong state shows up in the next acknowledge slot: the bench sees SDA high where it expects a low, or SDA still held low before a STOP.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_MACK,
    ST_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    LP_ENTRY,
    LP_RED,
    LP_GRN,
    LP_BLU
  } lut_phase_t;

endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // bit 1 = SCL, bit 0 = SDA; idle bus is high
  logic [1:0] stg [SYNC_DEPTH];
  logic [1:0] prev;

  generate
    for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 2'b11;
        else if (i == 0) stg[i] <= {scl_i, sda_i};
        else stg[i] <= stg[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 2'b11;
    else     prev <= stg[SYNC_DEPTH-1];
  end

  logic scl_now, sda_now;
  assign scl_now   = stg[SYNC_DEPTH-1][1];
  assign sda_now   = stg[SYNC_DEPTH-1][0];
  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~prev[1];
  assign scl_fall  = ~scl_now & prev[1];
  assign start_det = scl_now & prev[1] & prev[0] & ~sda_now;
  assign stop_det  = scl_now & prev[1] & ~prev[0] & sda_now;

endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic       wr_first,
  output logic [7:0] wr_byte,
  output logic       rd_take,
  output logic       xfer_start
);

  eng_state_t state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw;
  logic       first;
  logic       ackd;

  assign wr_byte  = sh;
  assign wr_first = first;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= 4'd0;
      sh         <= 8'd0;
      rw         <= 1'b0;
      first      <= 1'b0;
      ackd       <= 1'b0;
      sda_oe     <= 1'b0;
      wr_valid   <= 1'b0;
      rd_take    <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      wr_valid   <= 1'b0;
      rd_take    <= 1'b0;
      xfer_start <= 1'b0;
      if (start_det) begin
        state      <= ST_ADDR;
        cnt        <= 4'd0;
        sda_oe     <= 1'b0;
        xfer_start <= 1'b1;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= 4'd0;
              if (rw) begin
                sh      <= {rd_data[6:0], 1'b0};
                sda_oe  <= ~rd_data[7];
                rd_take <= 1'b1;
                state   <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                first  <= 1'b1;
                state  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) wr_valid <= 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd0;
              first  <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                ackd   <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~sh[7];
                sh     <= {sh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_WAIT;
              else       ackd  <= 1'b1;
            end else if (scl_fall && ackd) begin
              sh      <= {rd_data[6:0], 1'b0};
              sda_oe  <= ~rd_data[7];
              rd_take <= 1'b1;
              cnt     <= 4'd0;
              state   <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cs_reg_bank.sv
`timescale 1ns/1ps
module i2cs_reg_bank
  import i2cs_pkg::*;
#(
  parameter int         NREG     = 16,
  parameter int         LUT_AW   = 8,
  parameter logic [7:0] SUB_ID   = 8'h1C,
  parameter logic [7:0] SUB_STAT = 8'h1D,
  parameter logic [7:0] SUB_LUT  = 8'hFF,
  parameter logic [7:0] ID_VALUE = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_first,
  input  logic [7:0]        wr_byte,
  input  logic              rd_take,
  input  logic              xfer_start,
  input  logic              ovf_evt,
  input  logic              even_field,
  output logic [7:0]        rd_data,
  output logic [8*NREG-1:0] cfg_regs,
  output logic              lut_we,
  output logic [LUT_AW-1:0] lut_addr,
  output logic [23:0]       lut_rgb
);

  localparam int         IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic [7:0]        regs [NREG];
  logic [7:0]        ptr;
  logic              lut_mode;
  lut_phase_t        phase;
  logic [LUT_AW-1:0] entry;
  logic [7:0]        red_q, grn_q;
  logic              ovf_q;

  logic data_wr;
  assign data_wr = wr_valid && !wr_first && !lut_mode;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                            regs[g] <= 8'd0;
        else if (data_wr && ptr == 8'(g))   regs[g] <= wr_byte;
      end
      assign cfg_regs[8*g +: 8] = regs[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= 8'd0;
      lut_mode <= 1'b0;
      phase    <= LP_ENTRY;
      entry    <= '0;
      red_q    <= 8'd0;
      grn_q    <= 8'd0;
      lut_we   <= 1'b0;
      lut_addr <= '0;
      lut_rgb  <= 24'd0;
    end else begin
      lut_we <= 1'b0;
      if (xfer_start) begin
        lut_mode <= 1'b0;
        phase    <= LP_ENTRY;
      end else if (wr_valid && wr_first) begin
        ptr      <= wr_byte;
        lut_mode <= (wr_byte == SUB_LUT);
        phase    <= LP_ENTRY;
      end else if (wr_valid && lut_mode) begin
        case (phase)
          LP_ENTRY: begin
            entry <= wr_byte[LUT_AW-1:0];
            phase <= LP_RED;
          end
          LP_RED: begin
            red_q <= wr_byte;
            phase <= LP_GRN;
          end
          LP_GRN: begin
            grn_q <= wr_byte;
            phase <= LP_BLU;
          end
          default: begin
            lut_we   <= 1'b1;
            lut_addr <= entry;
            lut_rgb  <= {red_q, grn_q, wr_byte};
            entry    <= entry + 1'b1;
            phase    <= LP_RED;
          end
        endcase
      end else if (wr_valid || rd_take) begin
        ptr <= ptr + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              ovf_q <= 1'b0;
    else if (ovf_evt)                     ovf_q <= 1'b1;
    else if (rd_take && ptr == SUB_STAT)  ovf_q <= 1'b0;
  end

  always_comb begin
    rd_data = 8'h00;
    if (ptr < NREG_B)          rd_data = regs[ptr[IDX_W-1:0]];
    else if (ptr == SUB_ID)    rd_data = ID_VALUE;
    else if (ptr == SUB_STAT)  rd_data = {6'd0, even_field, ovf_q};
  end

endmodule

// File: rtl/i2c_reg_slave.sv
`timescale 1ns/1ps
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h44,
  parameter int         NREG       = 16,
  parameter int         LUT_AW     = 8,
  parameter int         SYNC_DEPTH = 2,
  parameter logic [7:0] SUB_ID     = 8'h1C,
  parameter logic [7:0] SUB_STAT   = 8'h1D,
  parameter logic [7:0] SUB_LUT    = 8'hFF,
  parameter logic [7:0] ID_VALUE   = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              ovf_evt,
  input  logic              even_field,
  output logic [8*NREG-1:0] cfg_regs,
  output logic              lut_we,
  output logic [LUT_AW-1:0] lut_addr,
  output logic [23:0]       lut_rgb
);

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_valid, wr_first, rd_take, xfer_start;
  logic [7:0] wr_byte, rd_data;

  i2cs_line_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .rd_data    (rd_data),
    .sda_oe     (sda_oe),
    .wr_valid   (wr_valid),
    .wr_first   (wr_first),
    .wr_byte    (wr_byte),
    .rd_take    (rd_take),
    .xfer_start (xfer_start)
  );

  i2cs_reg_bank #(
    .NREG     (NREG),
    .LUT_AW   (LUT_AW),
    .SUB_ID   (SUB_ID),
    .SUB_STAT (SUB_STAT),
    .SUB_LUT  (SUB_LUT),
    .ID_VALUE (ID_VALUE)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_first   (wr_first),
    .wr_byte    (wr_byte),
    .rd_take    (rd_take),
    .xfer_start (xfer_start),
    .ovf_evt    (ovf_evt),
    .even_field (even_field),
    .rd_data    (rd_data),
    .cfg_regs   (cfg_regs),
    .lut_we     (lut_we),
    .lut_addr   (lut_addr),
    .lut_rgb    (lut_rgb)
  );

endmodule

// File: rtl/i2cs_checker.sv
`timescale 1ns/1ps
module i2cs_checker #(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              lut_we,
  input logic [8*NREG-1:0] cfg_regs
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !lut_we && cfg_regs == '0)); // R9

  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i); // R10

  AST_LUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    lut_we |=> !lut_we); // R6

  AST_LUT_ON_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(lut_we) |-> scl_i); // R6

  AST_CFG_ON_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_regs) |-> scl_i); // R2

endmodule

bind i2c_reg_slave i2cs_checker #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .lut_we   (lut_we),
  .cfg_regs (cfg_regs)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;

  localparam int NREG   = 16;
  localparam int LUT_AW = 8;
  localparam int HALF   = 20;
  localparam int NVEC   = 7;
  // {subaddress, value written, value expected on read}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00A5A5, 24'h0F3C3C, 24'h07FFFF, 24'h030000,
    24'h0A8181, 24'h1C5502, 24'h207700
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic ovf_evt = 1'b0;
  logic even_field = 1'b0;
  logic sda_oe;
  logic [8*NREG-1:0] cfg_regs;
  logic lut_we;
  logic [LUT_AW-1:0] lut_addr;
  logic [23:0] lut_rgb;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_reg_slave #(.NREG(NREG), .LUT_AW(LUT_AW)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ovf_evt(ovf_evt), .even_field(even_field), .cfg_regs(cfg_regs),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_rgb(lut_rgb)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int lut_cnt = 0;
  logic [LUT_AW-1:0] lut_a [8];
  logic [23:0]       lut_d [8];
  always @(negedge clk) begin
    if (!rst && lut_we) begin
      if (lut_cnt < 8) begin
        lut_a[lut_cnt] = lut_addr;
        lut_d[lut_cnt] = lut_rgb;
      end
      lut_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hw(); scl_m = 1'b1; hw(); hw(); scl_m = 1'b0; hw();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); b = sda_line; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic nak;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(nak);
    ack = !nak;
  endtask

  task automatic rbyte(input bit last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(last);
  endtask

  logic [7:0] wbuf [10];
  logic [7:0] rbuf [4];

  task automatic do_write(input logic [7:0] sub, input int n, input string req);
    bit ack;
    bus_start();
    wbyte(8'h88, ack); chk(ack, "R1", "write address ack", ack, 1);
    wbyte(sub, ack);   chk(ack, "R10", "subaddress ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ack);
      chk(ack, req, "data byte ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] sub, input int n);
    bit ack;
    bus_start();
    wbyte(8'h88, ack);
    wbyte(sub, ack);
    bus_start();
    wbyte(8'h89, ack); chk(ack, "R1", "read address ack", ack, 1);
    for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
    chk(sda_oe == 1'b0, "R3", "SDA released after master NACK", sda_oe, 0);
    bus_stop();
  endtask

  function automatic logic [7:0] reg_at(input int k);
    return cfg_regs[8*k +: 8];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [8*NREG-1:0] snap;
    int base;
    repeat (10) @(negedge clk);
    // R9: reset state
    chk(sda_oe == 1'b0, "R9", "sda_oe in reset", sda_oe, 0);
    chk(lut_we == 1'b0, "R9", "lut_we in reset", lut_we, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(cfg_regs == '0, "R9", "registers after reset", cfg_regs[31:0], 0);
    do_read(8'h1D, 1);
    chk(rbuf[0] == 8'h00, "R9", "status after reset", rbuf[0], 0);

    // vector table: write one byte, read it back (R2, R4, R5)
    for (int v = 0; v < NVEC; v++) begin
      wbuf[0] = VEC[v][15:8];
      do_write(VEC[v][23:16], 1, "R10");
      do_read(VEC[v][23:16], 1);
      chk(rbuf[0] == VEC[v][7:0], (VEC[v][23:16] == 8'h1C) ? "R4" :
          (VEC[v][23:16] >= 8'(NREG)) ? "R5" : "R2",
          "vector readback", rbuf[0], VEC[v][7:0]);
    end

    // R2: burst write with auto-increment
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h04, 3, "R2");
    chk(reg_at(4) == 8'h11, "R2", "burst reg4", reg_at(4), 8'h11);
    chk(reg_at(5) == 8'h22, "R2", "burst reg5", reg_at(5), 8'h22);
    chk(reg_at(6) == 8'h33, "R2", "burst reg6", reg_at(6), 8'h33);

    // R3: burst read with auto-increment
    do_read(8'h04, 3);
    chk(rbuf[0] == 8'h11 && rbuf[1] == 8'h22 && rbuf[2] == 8'h33, "R3",
        "burst read", {rbuf[0], rbuf[1], rbuf[2]}, 24'h112233);
    // R3 / R4: read crossing unmapped, ID and status
    do_read(8'h1B, 3);
    chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h02 && rbuf[2] == 8'h00, "R4",
        "read across ID", {rbuf[0], rbuf[1], rbuf[2]}, 24'h000200);

    // R5: sticky overflow and field bit
    @(negedge clk); ovf_evt = 1'b1; @(negedge clk); ovf_evt = 1'b0;
    even_field = 1'b1;
    do_read(8'h1D, 1);
    chk(rbuf[0] == 8'h03, "R5", "status flag set, even field", rbuf[0], 8'h03);
    do_read(8'h1D, 1);
    chk(rbuf[0] == 8'h02, "R5", "flag cleared by read", rbuf[0], 8'h02);
    even_field = 1'b0;
    do_read(8'h1D, 1);
    chk(rbuf[0] == 8'h00, "R5", "odd field", rbuf[0], 8'h00);

    // R1: foreign address is not acknowledged and has no effect
    snap = cfg_regs;
    bus_start();
    wbyte(8'h8A, ack);
    chk(!ack, "R1", "foreign address nack", ack, 0);
    wbyte(8'h00, ack);
    wbyte(8'h99, ack);
    bus_stop();
    chk(cfg_regs == snap, "R1", "registers after foreign write", cfg_regs[31:0], snap[31:0]);

    // R6 / R7: colour table stream with trailing partial group
    snap = cfg_regs;
    base = lut_cnt;
    wbuf[0] = 8'h10;
    wbuf[1] = 8'h11; wbuf[2] = 8'h22; wbuf[3] = 8'h33;
    wbuf[4] = 8'h44; wbuf[5] = 8'h55; wbuf[6] = 8'h66;
    wbuf[7] = 8'h77;
    do_write(8'hFF, 8, "R6");
    chk(lut_cnt - base == 2, "R7", "table writes with partial tail", lut_cnt - base, 2);
    chk(lut_a[base] == 8'h10 && lut_d[base] == 24'h112233, "R6", "first entry",
        {lut_a[base], lut_d[base]}, 32'h10112233);
    chk(lut_a[base+1] == 8'h11 && lut_d[base+1] == 24'h445566, "R6", "second entry",
        {lut_a[base+1], lut_d[base+1]}, 32'h11445566);
    chk(cfg_regs == snap, "R6", "registers untouched by table stream", cfg_regs[31:0], snap[31:0]);
    base = lut_cnt;
    wbuf[0] = 8'h20; wbuf[1] = 8'hAA; wbuf[2] = 8'hBB;
    do_write(8'hFF, 3, "R7");
    chk(lut_cnt == base, "R7", "two-byte group discarded", lut_cnt - base, 0);

    // R8: STOP in mid-byte
    wbuf[0] = 8'h5A;
    do_write(8'h08, 1, "R8");
    bus_start();
    wbyte(8'h88, ack);
    wbyte(8'h08, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk(reg_at(8) == 8'h5A, "R8", "reg8 after mid-byte stop", reg_at(8), 8'h5A);
    // R8: repeated START in mid-byte, then a normal write
    bus_start();
    wbyte(8'h88, ack);
    wbyte(8'h08, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    wbyte(8'h88, ack);
    chk(ack, "R8", "address ack after repeated start", ack, 1);
    wbyte(8'h09, ack);
    wbyte(8'hC3, ack);
    bus_stop();
    chk(reg_at(9) == 8'hC3 && reg_at(8) == 8'h5A, "R8", "regs after repeated start",
        {reg_at(8), reg_at(9)}, 16'h5AC3);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule